// File: doc/BRIEF.md
# Time-Sliced Two-Master Memory Bus Multiplexer

This block shares one memory port between a DMA master and a CPU master by fixed time division rather than by arbitration. Each CPU cycle is made of two memory slots of one clock each. The first slot belongs only to the DMA side and the second belongs only to the CPU side. A phase register flips on every clock and acts as the select of the bus multiplexer. No request/grant handshake exists, so neither master ever waits on the other, and a change of owner costs no extra cycle.

Each master has its own address, write data, write strobe and request inputs, and its own registered read-data return with a one-cycle valid pulse. A request raised during the master's own slot is carried out in that same slot. A request raised during the other master's slot is held in the port, with its address, data and direction, until the next own slot. The memory is assumed to complete any access within one slot and to present read data combinationally during that slot.

States and transitions: the slot sequencer has states SLOT_DMA and SLOT_CPU, and it moves SLOT_DMA -> SLOT_CPU -> SLOT_DMA on every clock. Each master port has states PORT_IDLE and PORT_HELD. The port moves PORT_IDLE -> PORT_HELD when a request arrives outside its own slot, and PORT_HELD -> PORT_IDLE at the end of its own slot once the held access has been done. It stays in PORT_IDLE when a request arrives inside its own slot, because that request is served at once.

Top module: `slot_bus_mux`

## Requirements
- R1: While reset is active and right after it is released, `slot_cpu` is 0, `mem_en` and `mem_we` are 0, both `*_rvalid` are 0 and both `*_rdata` are 0.
- R2: `slot_cpu` is 0 (DMA slot) in the first cycle after reset release and then inverts on every clock.
- R3: When `slot_cpu` is 0, `mem_en`, `mem_we`, `mem_addr` and `mem_wdata` come only from the DMA side's access. CPU inputs have no effect.
- R4: When `slot_cpu` is 1, the memory signals come only from the CPU side's access. DMA inputs have no effect.
- R5: In a slot whose owner has neither a held request nor a live request, `mem_en` and `mem_we` are 0.
- R6: A request (`*_req`=1) raised in the master's own slot drives memory in that same cycle, using the live `*_we`, `*_addr` and `*_wdata`.
- R7: A request raised in the other master's slot is held. It is performed in the master's next slot with the address, data and direction captured when it was raised, even if those inputs have changed since.
- R8: A read (`*_we`=0) sets `*_rvalid` to 1 for exactly the cycle after its slot, with `*_rdata` equal to `mem_rdata` at the end of that slot. `*_rdata` keeps its value until the next read of the same master completes.
- R9: A write (`*_we`=1) produces no `*_rvalid` pulse and leaves `*_rdata` unchanged.
- R10: A request raised while the same master already holds a pending request is dropped. Only the first request appears on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one memory slot per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_req | input | 1 | DMA access request, one-cycle pulse |
| dma_we | input | 1 | DMA direction: 1 write, 0 read |
| dma_addr | input | ADDR_W | DMA memory address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_rvalid | output | 1 | DMA read data valid pulse |
| dma_rdata | output | DATA_W | DMA read data return register |
| cpu_req | input | 1 | CPU access request, one-cycle pulse |
| cpu_we | input | 1 | CPU direction: 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU memory address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rvalid | output | 1 | CPU read data valid pulse |
| cpu_rdata | output | DATA_W | CPU read data return register |
| slot_cpu | output | 1 | Current slot: 0 DMA, 1 CPU |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid within the slot |

## Verification
If the phase register goes wrong, the fault appears at `slot_cpu` and in which master's address reaches memory within one clock. Every following cycle then shows the wrong owner. If a port state goes wrong, the error shows within two clocks: a held access can be lost, repeated or carry stale fields, or memory can be enabled in an idle slot. A wrong capture shows up in the cycle after the slot, as a missing or spurious `*_rvalid` or a wrong `*_rdata` value. The bench keeps a cycle-accurate model of both ports and compares every memory-side and return signal in every cycle, so any of these faults is caught in the cycle it first appears.

// File: rtl/slot_mux_pkg.sv
package slot_mux_pkg;

    typedef enum logic {
        SLOT_DMA = 1'b0,
        SLOT_CPU = 1'b1
    } slot_e;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_HELD = 1'b1
    } port_state_e;

    localparam int NUM_MASTERS = 2;

endpackage

// File: rtl/slot_phase_fsm.sv
module slot_phase_fsm
    import slot_mux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e cur_slot
);

    slot_e state_q;
    slot_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_DMA;
        else        state_q <= state_d;
    end

    // transitions: every clock hands the bus to the other side
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_DMA: state_d = SLOT_CPU;
            SLOT_CPU: state_d = SLOT_DMA;
        endcase
    end

    assign cur_slot = state_q;

endmodule

// File: rtl/slot_master_port.sv
module slot_master_port
    import slot_mux_pkg::*;
#(
    parameter int    ADDR_W   = 16,
    parameter int    DATA_W   = 32,
    parameter slot_e OWN_SLOT = SLOT_DMA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             cur_slot,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              acc_en,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    port_state_e       state_q;
    port_state_e       state_d;
    logic              own_slot;
    logic              hold_we_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_wdata_q;
    logic              capture;

    assign own_slot = (cur_slot == OWN_SLOT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (req && !own_slot) state_d = PORT_HELD;
            PORT_HELD: if (own_slot)         state_d = PORT_IDLE;
        endcase
    end

    // held access fields, loaded only when entering PORT_HELD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_we_q    <= 1'b0;
            hold_addr_q  <= '0;
            hold_wdata_q <= '0;
        end else if (state_q == PORT_IDLE && req && !own_slot) begin
            hold_we_q    <= we;
            hold_addr_q  <= addr;
            hold_wdata_q <= wdata;
        end
    end

    // outputs toward the bus selector
    always_comb begin
        acc_en    = 1'b0;
        acc_we    = 1'b0;
        acc_addr  = addr;
        acc_wdata = wdata;
        unique case (state_q)
            PORT_IDLE: begin
                acc_en    = req && own_slot;
                acc_we    = req && own_slot && we;
                acc_addr  = addr;
                acc_wdata = wdata;
            end
            PORT_HELD: begin
                acc_en    = own_slot;
                acc_we    = own_slot && hold_we_q;
                acc_addr  = hold_addr_q;
                acc_wdata = hold_wdata_q;
            end
        endcase
    end

    // read return: captured at the end of the own slot
    assign capture = acc_en && !acc_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= mem_rdata;
        end
    end

endmodule

// File: rtl/slot_bus_select.sv
module slot_bus_select #(
    parameter int N      = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [SEL_W-1:0]           sel,
    input  logic [N-1:0]               en_in,
    input  logic [N-1:0]               we_in,
    input  logic [N-1:0][ADDR_W-1:0]   addr_in,
    input  logic [N-1:0][DATA_W-1:0]   wdata_in,
    output logic                       mem_en,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata
);

    // owner change is a select change only
    always_comb begin
        mem_en    = en_in[sel];
        mem_we    = en_in[sel] && we_in[sel];
        mem_addr  = addr_in[sel];
        mem_wdata = wdata_in[sel];
    end

endmodule

// File: rtl/slot_bus_mux.sv
module slot_bus_mux
    import slot_mux_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              dma_rvalid,
    output logic [DATA_W-1:0] dma_rdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              slot_cpu,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int N     = NUM_MASTERS;
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    slot_e                     cur_slot;
    logic [N-1:0]              m_req;
    logic [N-1:0]              m_we;
    logic [N-1:0][ADDR_W-1:0]  m_addr;
    logic [N-1:0][DATA_W-1:0]  m_wdata;
    logic [N-1:0]              a_en;
    logic [N-1:0]              a_we;
    logic [N-1:0][ADDR_W-1:0]  a_addr;
    logic [N-1:0][DATA_W-1:0]  a_wdata;
    logic [N-1:0]              r_valid;
    logic [N-1:0][DATA_W-1:0]  r_data;
    logic [SEL_W-1:0]          sel;

    // index 0 = DMA (slot 0), index 1 = CPU (slot 1)
    assign m_req   = {cpu_req,   dma_req};
    assign m_we    = {cpu_we,    dma_we};
    assign m_addr  = {cpu_addr,  dma_addr};
    assign m_wdata = {cpu_wdata, dma_wdata};

    slot_phase_fsm u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_slot (cur_slot)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_port
            slot_master_port #(
                .ADDR_W   (ADDR_W),
                .DATA_W   (DATA_W),
                .OWN_SLOT (slot_e'(g))
            ) u_port (
                .clk       (clk),
                .rst_n     (rst_n),
                .cur_slot  (cur_slot),
                .req       (m_req[g]),
                .we        (m_we[g]),
                .addr      (m_addr[g]),
                .wdata     (m_wdata[g]),
                .mem_rdata (mem_rdata),
                .acc_en    (a_en[g]),
                .acc_we    (a_we[g]),
                .acc_addr  (a_addr[g]),
                .acc_wdata (a_wdata[g]),
                .rvalid    (r_valid[g]),
                .rdata     (r_data[g])
            );
        end
    endgenerate

    assign sel = SEL_W'(cur_slot);

    slot_bus_select #(
        .N      (N),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sel (
        .sel       (sel),
        .en_in     (a_en),
        .we_in     (a_we),
        .addr_in   (a_addr),
        .wdata_in  (a_wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign slot_cpu   = (cur_slot == SLOT_CPU);
    assign dma_rvalid = r_valid[0];
    assign dma_rdata  = r_data[0];
    assign cpu_rvalid = r_valid[1];
    assign cpu_rdata  = r_data[1];

endmodule

// File: rtl/slot_bus_mux_chk.sv
module slot_bus_mux_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_cpu,
    input logic              mem_en,
    input logic              mem_we,
    input logic              dma_rvalid,
    input logic [DATA_W-1:0] dma_rdata,
    input logic              cpu_rvalid,
    input logic [DATA_W-1:0] cpu_rdata
);

    AST_SLOT_DMA_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_cpu |=> slot_cpu);                                           // R2
    AST_SLOT_CPU_TO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cpu |=> !slot_cpu);                                           // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> !mem_we);                                              // R5
    AST_DMA_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rvalid |-> $past(!slot_cpu && mem_en && !mem_we));             // R8
    AST_CPU_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(slot_cpu && mem_en && !mem_we));              // R8
    AST_DMA_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_rvalid |-> $stable(dma_rdata));                               // R8
    AST_CPU_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rvalid |-> $stable(cpu_rdata));                               // R8
    AST_DMA_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_cpu && mem_en && mem_we) |=> !dma_rvalid);                  // R9
    AST_CPU_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cpu && mem_en && mem_we) |=> !cpu_rvalid);                   // R9

endmodule

bind slot_bus_mux slot_bus_mux_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_cpu   (slot_cpu),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .dma_rvalid (dma_rvalid),
    .dma_rdata  (dma_rdata),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata)
);

// File: tb/slot_bus_mux_bench.sv
`timescale 1ns/1ps
module slot_bus_mux_bench;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    req = '0;
    logic [1:0]    we = '0;
    logic [AW-1:0] addr [2];
    logic [DW-1:0] wdata [2];
    logic          dma_rvalid, cpu_rvalid, slot_cpu, mem_en, mem_we;
    logic [DW-1:0] dma_rdata, cpu_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    bit          m_slot;
    bit [1:0]    m_pend;
    bit [1:0]    m_hwe;
    bit [AW-1:0] m_haddr [2];
    bit [DW-1:0] m_hwdata [2];
    bit [1:0]    m_rv;
    bit [DW-1:0] m_rd [2];

    always #4 clk = ~clk;  // 125 MHz

    function automatic logic [DW-1:0] mem_model(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    assign mem_rdata = mem_model(mem_addr);

    slot_bus_mux #(.ADDR_W(AW), .DATA_W(DW)) u_slot_bus_mux (
        .clk(clk), .rst_n(rst_n),
        .dma_req(req[0]), .dma_we(we[0]), .dma_addr(addr[0]), .dma_wdata(wdata[0]),
        .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
        .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]), .cpu_wdata(wdata[1]),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .slot_cpu(slot_cpu), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: inputs already driven; check mid-cycle, advance model, wait next negedge
    task automatic step(input string addr_tag);
        bit          o;
        bit          act, ewe;
        bit [AW-1:0] ea;
        bit [DW-1:0] ew;
        bit [1:0]    nrv;
        #1;
        o = m_slot;
        act = m_pend[o] | req[o];
        ewe = m_pend[o] ? m_hwe[o] : we[o];
        ea  = m_pend[o] ? m_haddr[o] : addr[o];
        ew  = m_pend[o] ? m_hwdata[o] : wdata[o];
        check("R2", "slot_cpu", DW'(slot_cpu), DW'(o));
        check(!act ? "R5" : (o ? "R4" : "R3"), "mem_en", DW'(mem_en), DW'(act));
        check(!act ? "R5" : (o ? "R4" : "R3"), "mem_we", DW'(mem_we), DW'(act & ewe));
        if (act) begin
            check(addr_tag != "" ? addr_tag : (m_pend[o] ? "R7" : "R6"), "mem_addr",
                  DW'(mem_addr), DW'(ea));
            if (ewe) check(m_pend[o] ? "R7" : "R6", "mem_wdata", mem_wdata, ew);
        end
        check("R8", "dma_rvalid", DW'(dma_rvalid), DW'(m_rv[0]));
        check("R9", "dma_rdata",  dma_rdata, m_rd[0]);
        check("R8", "cpu_rvalid", DW'(cpu_rvalid), DW'(m_rv[1]));
        check("R9", "cpu_rdata",  cpu_rdata, m_rd[1]);
        // advance model to the next edge
        nrv = '0;
        for (int i = 0; i < 2; i++) begin
            if (i == int'(o)) begin
                if (act && !ewe) begin
                    nrv[i] = 1'b1;
                    m_rd[i] = mem_model(ea);
                end
                m_pend[i] = 1'b0;
            end else if (req[i] && !m_pend[i]) begin
                m_pend[i]   = 1'b1;
                m_hwe[i]    = we[i];
                m_haddr[i]  = addr[i];
                m_hwdata[i] = wdata[i];
            end
        end
        m_rv = nrv;
        m_slot = ~m_slot;
        @(negedge clk);
    endtask

    task automatic drive(input int i, input bit r, input bit w,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        req[i] = r; we[i] = w; addr[i] = a; wdata[i] = d;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
        m_slot = 0; m_pend = '0; m_hwe = '0; m_rv = '0;
        m_rd[0] = '0; m_rd[1] = '0;
        m_haddr[0] = '0; m_haddr[1] = '0; m_hwdata[0] = '0; m_hwdata[1] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "slot_cpu",   DW'(slot_cpu), '0);
        check("R1", "mem_en",     DW'(mem_en), '0);
        check("R1", "mem_we",     DW'(mem_we), '0);
        check("R1", "dma_rvalid", DW'(dma_rvalid), '0);
        check("R1", "cpu_rvalid", DW'(cpu_rvalid), '0);
        check("R1", "dma_rdata",  dma_rdata, '0);
        check("R1", "cpu_rdata",  cpu_rdata, '0);
        rst_n = 1'b1;
        check("R1", "slot_cpu after release", DW'(slot_cpu), '0);
        // idle slots (R5)
        step(""); step("");
        // R6: DMA read in own slot
        drive(0, 1, 0, 16'h1234, '0); step("R6");
        drive(0, 0, 0, '0, '0);
        // R7: CPU request in DMA slot... now CPU slot; CPU write in own slot (R6)
        drive(1, 1, 1, 16'h0042, 32'hCAFE0001); step("R6");
        drive(1, 0, 0, '0, '0);
        // DMA slot: CPU read arrives outside its slot -> held (R7)
        drive(1, 1, 0, 16'hBEEF, '0); step("");
        // CPU slot: inputs changed, held fields must be used
        drive(1, 0, 1, 16'hFFFF, 32'h5555AAAA); step("R7");
        drive(1, 0, 0, '0, '0);
        // DMA in CPU slot: first request held, second ignored (R10)
        step("");
        drive(0, 1, 1, 16'h0A0A, 32'h11112222); step("");   // now CPU slot? sync below
        drive(0, 0, 0, '0, '0);
        // ensure a double request sequence independent of phase
        if (m_slot == 1'b0) step("");
        drive(0, 1, 0, 16'h7777, '0); step("");             // CPU slot: DMA held
        drive(0, 0, 0, '0, '0);
        drive(0, 1, 0, 16'h9999, '0);                        // DMA slot: pending served
        step("R10");
        drive(0, 0, 0, '0, '0);
        drive(0, 1, 0, 16'h8888, '0); step("");             // CPU slot: held again
        drive(0, 1, 0, 16'h6666, '0); step("R10");          // DMA slot: 8888 served, 6666 dropped
        drive(0, 0, 0, '0, '0);
        step(""); step(""); step("");
        // constrained random traffic
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < 2; i++)
                drive(i, ($urandom_range(0, 9) < 4), $urandom_range(0, 1),
                      AW'($urandom), $urandom);
            step("");
        end
        drive(0, 0, 0, '0, '0); drive(1, 0, 0, '0, '0);
        step(""); step(""); step("");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule